// File: doc/BRIEF.md
# Processor Execution State Controller

This block tracks the execution state of a small 16-bit processor core. At any moment the core is running user code (normal), servicing an exception in supervisor mode (exception), or stopped (halted). The controller watches reset requests, double-bus-fault reports, the external halt line, exception requests, instruction boundaries, and return or status-register write events. From these it keeps the state, the supervisor flag and a run enable for the instruction sequencer.

User code must not return from an exception, write the status register, or run any other privileged operation. When it tries, the controller flags a privilege violation and moves the core into exception state. There are two ways to halt. A halt requested on the external line ends when the line is released. A double bus fault locks the core halted until a reset request arrives.

Top module: `exec_state_ctrl`

## Requirements
- R1: The `state` output is one-hot. Bit 0 means normal, bit 1 means exception and bit 2 means halted. While `rst_n` is low, and after it rises, the block is in exception state with `s_flag`=1, `run_en`=1 and `state_change`=0.
- R2: `s_flag` is 0 in normal state and 1 in exception and halted states.
- R3: `reset_req` outranks every other input. At the next clock edge it moves the block to exception state from any state, and it clears a latched double-bus fault.
- R4: When `dbl_fault` is high and `reset_req` is low, the block goes to halted state at the next edge. It then stays halted, whatever `halt_line` and `exc_req` do, until `reset_req` arrives.
- R5: In normal or exception state, `halt_line` moves the block to halted state only on a cycle where `insn_done` is also high. Without `insn_done`, `halt_line` has no effect.
- R6: In a halt entered through `halt_line`, the block returns to normal state at the first edge where `halt_line` is low.
- R7: In normal state, `exc_req` moves the block to exception state at the next edge.
- R8: In normal state, `priv_op`, `rte_ev` or `sr_wr_ev` sets `priv_viol` high in the same cycle and moves the block to exception state at the next edge. In exception state these inputs never set `priv_viol`.
- R9: In exception state, `rte_ev` returns the block to normal state. So does `sr_wr_ev` with `sr_wr_s`=0. `sr_wr_ev` with `sr_wr_s`=1 leaves the state unchanged.
- R10: `run_en` is low exactly when the block is in halted state.
- R11: `state_change` is high for one cycle. That cycle is the first one in which `state` shows a new value.
- R12: Below reset, the priority order is: double fault first, then halt at an instruction boundary, then an exception, privilege violation or return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_req | input | 1 | Reset exception request |
| dbl_fault | input | 1 | Double bus fault reported |
| halt_line | input | 1 | External halt request, level |
| insn_done | input | 1 | Instruction boundary pulse |
| exc_req | input | 1 | Exception or interrupt request |
| priv_op | input | 1 | Privileged operation (stop, reset, user stack move) attempted |
| rte_ev | input | 1 | Return-from-exception executed |
| sr_wr_ev | input | 1 | Status register write executed |
| sr_wr_s | input | 1 | S bit carried by the status register write |
| state | output | 3 | One-hot state: bit 0 normal, bit 1 exception, bit 2 halted |
| s_flag | output | 1 | Supervisor flag |
| run_en | output | 1 | Sequencer run enable |
| priv_viol | output | 1 | Privilege violation detected this cycle |
| state_change | output | 1 | One-cycle pulse on a state update |

## Verification
The assertions assume that the event inputs are synchronous to `clk` and stable around the rising edge. They also assume the core raises `rte_ev` or `sr_wr_ev` only for instructions it has actually executed, and they allow any combination of inputs in the same cycle. The stimulus drives every input on the falling edge. It walks through state sequences, including cycles where several requests collide, so that each priority rule is exercised from a known starting state. It also pulses `rst_n` in the middle of a run, while a fault is latched.

// File: rtl/exec_state_ctrl.sv
module exec_state_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reset_req,
  input  logic       dbl_fault,
  input  logic       halt_line,
  input  logic       insn_done,
  input  logic       exc_req,
  input  logic       priv_op,
  input  logic       rte_ev,
  input  logic       sr_wr_ev,
  input  logic       sr_wr_s,
  output logic [2:0] state,
  output logic       s_flag,
  output logic       run_en,
  output logic       priv_viol,
  output logic       state_change
);
  localparam int NRM = 0;
  localparam int EXC = 1;
  localparam int HLT = 2;
  localparam logic [2:0] ST_NRM = 3'b001;
  localparam logic [2:0] ST_EXC = 3'b010;
  localparam logic [2:0] ST_HLT = 3'b100;

  logic [2:0] st_q, st_d;
  logic       fault_q, fault_d;
  logic       chg_q;
  logic       halt_take;

  assign halt_take = halt_line & insn_done;
  assign priv_viol = st_q[NRM] & (priv_op | rte_ev | sr_wr_ev);

  always_comb begin
    st_d    = st_q;
    fault_d = fault_q;
    if (reset_req) begin
      st_d    = ST_EXC;
      fault_d = 1'b0;
    end else if (dbl_fault) begin
      st_d    = ST_HLT;
      fault_d = 1'b1;
    end else if (st_q[NRM]) begin
      if (halt_take)                   st_d = ST_HLT;
      else if (exc_req || priv_viol)   st_d = ST_EXC;
    end else if (st_q[EXC]) begin
      if (halt_take)                           st_d = ST_HLT;
      else if (rte_ev || (sr_wr_ev && !sr_wr_s)) st_d = ST_NRM;
    end else begin
      if (!fault_q && !halt_line) st_d = ST_NRM;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_EXC;
      fault_q <= 1'b0;
      chg_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      fault_q <= fault_d;
      chg_q   <= (st_d != st_q);
    end
  end

  assign state        = st_q;
  assign s_flag       = ~st_q[NRM];
  assign run_en       = ~st_q[HLT];
  assign state_change = chg_q;
endmodule

module exec_state_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reset_req,
  input logic       dbl_fault,
  input logic       halt_line,
  input logic       insn_done,
  input logic       exc_req,
  input logic       rte_ev,
  input logic       sr_wr_ev,
  input logic       sr_wr_s,
  input logic [2:0] state,
  input logic       s_flag,
  input logic       run_en,
  input logic       priv_viol,
  input logic       state_change,
  input logic       fault_q
);
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state) == 1);

  p_sflag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state[0] |-> !s_flag) and (!state[0] |-> s_flag));

  p_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> (state == 3'b010) && !fault_q);

  p_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_fault && !reset_req) |=> state == 3'b100);

  p_fault_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state[2] && fault_q && !reset_req) |=> state[2]);

  p_halt_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!state[2] && halt_line && !insn_done && !dbl_fault) |=> !state[2]);

  p_priv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_viol && !reset_req && !dbl_fault && !(halt_line && insn_done)) |=> state[1]);

  p_priv_exc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !state[0] |-> !priv_viol);

  p_srkeep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state[1] && sr_wr_ev && sr_wr_s && !rte_ev && !reset_req && !dbl_fault
     && !(halt_line && insn_done)) |=> state[1]);

  p_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run_en == !state[2]);

  p_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
    state_change == (state != $past(state)));

  p_prio_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_req && !dbl_fault && !state[2] && halt_line && insn_done) |=> state[2]);

  p_exc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state[0] && exc_req && !reset_req && !dbl_fault && !(halt_line && insn_done))
    |=> state[1]);
endmodule

bind exec_state_ctrl exec_state_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .dbl_fault(dbl_fault),
  .halt_line(halt_line), .insn_done(insn_done), .exc_req(exc_req),
  .rte_ev(rte_ev), .sr_wr_ev(sr_wr_ev), .sr_wr_s(sr_wr_s), .state(state),
  .s_flag(s_flag), .run_en(run_en), .priv_viol(priv_viol),
  .state_change(state_change), .fault_q(fault_q)
);

// File: tb/exec_state_ctrl_bench.sv
module exec_state_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reset_req = 0, dbl_fault = 0, halt_line = 0, insn_done = 0, exc_req = 0;
  logic priv_op = 0, rte_ev = 0, sr_wr_ev = 0, sr_wr_s = 0;
  logic [2:0] state;
  logic s_flag, run_en, priv_viol, state_change;
  int total = 0, bad = 0, cycles = 0;

  always #5 clk = ~clk;

  exec_state_ctrl u_exec_state_ctrl (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .dbl_fault(dbl_fault),
    .halt_line(halt_line), .insn_done(insn_done), .exc_req(exc_req),
    .priv_op(priv_op), .rte_ev(rte_ev), .sr_wr_ev(sr_wr_ev), .sr_wr_s(sr_wr_s),
    .state(state), .s_flag(s_flag), .run_en(run_en), .priv_viol(priv_viol),
    .state_change(state_change)
  );

  localparam logic [2:0] N = 3'b001, E = 3'b010, H = 3'b100;
  // {reset_req,dbl_fault,halt_line,insn_done,exc_req,priv_op,rte_ev,sr_wr_ev,sr_wr_s}, next state, priv_viol, change
  localparam int NV = 30;
  localparam logic [13:0] VEC [NV] = '{
    {9'b000000000, E, 1'b0, 1'b0},
    {9'b000000100, N, 1'b0, 1'b1},
    {9'b000000000, N, 1'b0, 1'b0},
    {9'b001000000, N, 1'b0, 1'b0},
    {9'b001100000, H, 1'b0, 1'b1},
    {9'b001000000, H, 1'b0, 1'b0},
    {9'b000000000, N, 1'b0, 1'b1},
    {9'b000010000, E, 1'b0, 1'b1},
    {9'b000000011, E, 1'b0, 1'b0},
    {9'b000000010, N, 1'b0, 1'b1},
    {9'b000001000, E, 1'b1, 1'b1},
    {9'b000000100, N, 1'b0, 1'b1},
    {9'b000000100, E, 1'b1, 1'b1},
    {9'b000000010, N, 1'b0, 1'b1},
    {9'b000000011, E, 1'b1, 1'b1},
    {9'b010000000, H, 1'b0, 1'b1},
    {9'b000000000, H, 1'b0, 1'b0},
    {9'b000010000, H, 1'b0, 1'b0},
    {9'b100000000, E, 1'b0, 1'b1},
    {9'b000000100, N, 1'b0, 1'b1},
    {9'b011110000, H, 1'b0, 1'b1},
    {9'b110000000, E, 1'b0, 1'b1},
    {9'b000000000, E, 1'b0, 1'b0},
    {9'b000000100, N, 1'b0, 1'b1},
    {9'b001111000, H, 1'b1, 1'b1},
    {9'b000000000, N, 1'b0, 1'b1},
    {9'b100000000, E, 1'b0, 1'b1},
    {9'b000000100, N, 1'b0, 1'b1},
    {9'b001100000, H, 1'b0, 1'b1},
    {9'b101000000, E, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_outs(input logic [2:0] exp_st, input logic exp_ch, input string tag);
    chk({tag, " R1 state"}, state, exp_st);
    chk("R2 s_flag", {2'b0, s_flag}, {2'b0, ~exp_st[0]});
    chk("R10 run_en", {2'b0, run_en}, {2'b0, ~exp_st[2]});
    chk("R11 state_change", {2'b0, state_change}, {2'b0, exp_ch});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk_outs(E, 1'b0, "reset-held");
    rst_n = 1'b1;
    @(negedge clk);
    chk_outs(E, 1'b0, "after-reset");
    for (int i = 0; i < NV; i++) begin
      {reset_req, dbl_fault, halt_line, insn_done, exc_req, priv_op, rte_ev, sr_wr_ev, sr_wr_s} = VEC[i][13:5];
      #1;
      chk("R8 priv_viol", {2'b0, priv_viol}, {2'b0, VEC[i][1]});
      @(negedge clk);
      chk_outs(VEC[i][4:2], VEC[i][0], $sformatf("vec%0d R3 R4 R5 R6 R7 R9 R12", i));
    end
    {reset_req, dbl_fault, halt_line, insn_done, exc_req, priv_op, rte_ev, sr_wr_ev, sr_wr_s} = '0;
    rte_ev = 1; @(negedge clk); rte_ev = 0;
    dbl_fault = 1; @(negedge clk); dbl_fault = 0;
    chk_outs(H, 1'b1, "R4 fault halt");
    rst_n = 0; #2;
    chk_outs(E, 1'b0, "R1 async reset");
    @(negedge clk); rst_n = 1;
    rte_ev = 1; @(negedge clk); rte_ev = 0;
    chk_outs(N, 1'b1, "R9 fault cleared by rst_n");
    halt_line = 1; insn_done = 1; @(negedge clk); insn_done = 0;
    @(negedge clk);
    chk_outs(H, 1'b0, "R6 halt held");
    halt_line = 0; @(negedge clk);
    chk_outs(N, 1'b1, "R6 release");
    @(negedge clk);
    chk_outs(N, 1'b0, "R11 pulse one cycle");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule